// File: doc/BRIEF.md
# Configurable FIFO Parity Stage

This block sits between a 9-bit FIFO interface and the FIFO's storage array. On the write side it turns the incoming 9-bit word into the word that is actually stored. On the read side it turns the stored word back into the outward data bus plus two dedicated pins. The stored ninth bit (bit 8) has one of three meanings, chosen by a programmed mode. It can be plain data. It can be a parity bit generated from the low byte. It can be the result of checking the parity of the full incoming word.

The mode and the odd/even polarity are static configuration ports. Each write captures them at its own clock edge, so a mode change only alters words written after the change. The read-side mapping uses the mode present at the time of the read. Software therefore changes the mode only while no words of the old mode are waiting to be read. The storage array is outside this block. Both paths are registered with one cycle of latency.

Top module: `fifo_parity_stage`

## Requirements
- R1: With mode 2'b00 (pass-through), a write stores all nine bits of `wr_data` unchanged.
- R2: With mode 2'b01 (generate), stored bits 7..0 equal `wr_data[7:0]`, stored bit 8 is a parity bit computed over `wr_data[7:0]` only, and `wr_data[8]` has no effect on the stored word.
- R3: In generate mode with `cfg_odd`=1, stored bit 8 is 1 exactly when `wr_data[7:0]` has an even number of ones; with `cfg_odd`=0, it is 1 exactly when that count is odd.
- R4: With mode 2'b10 (check), stored bits 7..0 equal `wr_data[7:0]`. Stored bit 8 is 1 when the number of ones over all nine input bits is odd for `cfg_odd`=1, or even for `cfg_odd`=0, and is 0 otherwise.
- R5: Reading in generate mode drives `rd_par` to stored bit 8 and `rd_data` to {1'b0, stored bits 7..0}, with `rd_good` held at 1.
- R6: Reading in check mode drives `rd_good` to stored bit 8, so that a word which failed its check reads with `rd_good` low. It also drives `rd_data` to {1'b0, stored bits 7..0}, with `rd_par` at 0.
- R7: Reading in pass-through mode drives `rd_data` to the full stored word, with `rd_par` at 0 and `rd_good` at 1.
- R8: Mode 2'b11 behaves exactly as pass-through on both the write and the read path.
- R9: `st_valid` and `st_word` follow `wr_en` by one clock cycle, using the mode and polarity present at that write's edge. A mode change between two back-to-back writes affects only the later write.
- R10: `rd_valid`, `rd_data`, `rd_par` and `rd_good` follow `rd_en` by one clock cycle.
- R11: While `rst_n` is low, `st_valid`=0, `st_word`=0, `rd_valid`=0, `rd_data`=0, `rd_par`=0 and `rd_good`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | 00 pass, 01 generate, 10 check, 11 pass |
| cfg_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W+1 | Incoming word |
| st_valid | output | 1 | Stored word is valid this cycle |
| st_word | output | DATA_W+1 | Word to place in storage |
| rd_en | input | 1 | Read strobe |
| rd_word | input | DATA_W+1 | Word fetched from storage |
| rd_valid | output | 1 | Read outputs are valid this cycle |
| rd_data | output | DATA_W+1 | Outward data bus |
| rd_par | output | 1 | Generated parity of the word read |
| rd_good | output | 1 | Check result, low on a word that failed |

## Verification
The bench builds the block with DATA_W=8, the width the requirements are written for. At this width the bench can sweep every one of the 256 low-byte values in generate mode under both polarities. It can also sweep all 512 nine-bit words in check mode under both polarities. This reaches every parity outcome and every value of the ignored bit 8. A final burst changes the mode on every cycle across back-to-back writes. It also uses mode 11, covering write-time sampling and the alias of mode 11 to pass-through.

// File: rtl/fifo_parity_stage.sv
module fifo_parity_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_odd,
  input  logic              wr_en,
  input  logic [DATA_W:0]   wr_data,
  output logic              st_valid,
  output logic [DATA_W:0]   st_word,
  input  logic              rd_en,
  input  logic [DATA_W:0]   rd_word,
  output logic              rd_valid,
  output logic [DATA_W:0]   rd_data,
  output logic              rd_par,
  output logic              rd_good
);
  localparam int W = DATA_W + 1;
  localparam logic [1:0] M_GEN = 2'b01;
  localparam logic [1:0] M_CHK = 2'b10;

  logic          gen_bit, chk_bit;
  logic [W-1:0]  wr_next;
  logic [W-1:0]  rd_next;
  logic          par_next, good_next;

  assign gen_bit = (^wr_data[DATA_W-1:0]) ^ cfg_odd;
  assign chk_bit = ~((^wr_data) ^ cfg_odd);

  always_comb begin
    case (cfg_mode)
      M_GEN:   wr_next = {gen_bit, wr_data[DATA_W-1:0]};
      M_CHK:   wr_next = {chk_bit, wr_data[DATA_W-1:0]};
      default: wr_next = wr_data;
    endcase
  end

  always_comb begin
    rd_next   = rd_word;
    par_next  = 1'b0;
    good_next = 1'b1;
    case (cfg_mode)
      M_GEN: begin
        rd_next  = {1'b0, rd_word[DATA_W-1:0]};
        par_next = rd_word[DATA_W];
      end
      M_CHK: begin
        rd_next   = {1'b0, rd_word[DATA_W-1:0]};
        good_next = rd_word[DATA_W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_word  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_par   <= 1'b0;
      rd_good  <= 1'b1;
    end else begin
      st_valid <= wr_en;
      if (wr_en) st_word <= wr_next;
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= rd_next;
        rd_par  <= par_next;
        rd_good <= good_next;
      end
    end
  end
endmodule

// File: rtl/fifo_parity_stage_chk.sv
module fifo_parity_stage_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_mode,
  input logic              cfg_odd,
  input logic              wr_en,
  input logic [DATA_W:0]   wr_data,
  input logic              st_valid,
  input logic [DATA_W:0]   st_word,
  input logic              rd_en,
  input logic [DATA_W:0]   rd_word,
  input logic              rd_valid,
  input logic [DATA_W:0]   rd_data,
  input logic              rd_par,
  input logic              rd_good
);
  logic is_pass;
  assign is_pass = (cfg_mode == 2'b00) || (cfg_mode == 2'b11);

  // R1 and R8
  a_r1_pass_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_pass) |=> (st_word == $past(wr_data)));

  a_r2_gen_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_mode == 2'b01) |=>
      (st_word[DATA_W-1:0] == $past(wr_data[DATA_W-1:0])) &&
      (st_word[DATA_W] == ((^$past(wr_data[DATA_W-1:0])) ^ $past(cfg_odd))));

  a_r4_chk_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_mode == 2'b10) |=>
      (st_word[DATA_W-1:0] == $past(wr_data[DATA_W-1:0])) &&
      (st_word[DATA_W] == ((^$past(wr_data)) == $past(cfg_odd))));

  a_r9_st_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> st_valid);

  a_r9_st_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !st_valid);

  a_r5_rd_gen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cfg_mode == 2'b01) |=>
      rd_valid && rd_good && !rd_data[DATA_W] && (rd_par == $past(rd_word[DATA_W])));

  a_r6_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cfg_mode == 2'b10) |=>
      rd_valid && !rd_par && !rd_data[DATA_W] && (rd_good == $past(rd_word[DATA_W])));

  // R7 and R8
  a_r7_rd_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_pass) |=>
      rd_valid && !rd_par && rd_good && (rd_data == $past(rd_word)));

  a_r10_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind fifo_parity_stage fifo_parity_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_odd(cfg_odd),
  .wr_en(wr_en), .wr_data(wr_data), .st_valid(st_valid), .st_word(st_word),
  .rd_en(rd_en), .rd_word(rd_word), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_par(rd_par), .rd_good(rd_good)
);

// File: tb/tb_fifo_parity_stage.sv
`timescale 1ns/1ps
module tb_fifo_parity_stage;
  localparam int DW = 8;
  localparam int DEPTH = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_odd = 1'b0;
  logic wr_en = 1'b0;
  logic [DW:0] wr_data = '0;
  logic st_valid;
  logic [DW:0] st_word;
  logic rd_en = 1'b0;
  logic [DW:0] rd_word = '0;
  logic rd_valid;
  logic [DW:0] rd_data;
  logic rd_par, rd_good;

  always #4 clk = ~clk;

  fifo_parity_stage #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_odd(cfg_odd),
    .wr_en(wr_en), .wr_data(wr_data), .st_valid(st_valid), .st_word(st_word),
    .rd_en(rd_en), .rd_word(rd_word), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_par(rd_par), .rd_good(rd_good)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [DW:0]   st_q[$];
  string         st_tag[$];
  logic [DW+2:0] rd_q[$];
  string         rd_tag[$];
  logic [DW:0]   mem[DEPTH];
  logic [1:0]    wmode[DEPTH];
  int            wpush = 0;
  int            wstore = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW:0] exp_store(logic [DW:0] d, logic [1:0] m, logic odd);
    case (m)
      2'b01:   return {(^d[DW-1:0]) ^ odd, d[DW-1:0]};
      2'b10:   return {((^d) == odd), d[DW-1:0]};
      default: return d;
    endcase
  endfunction

  function automatic string mode_tag(logic [1:0] m, bit rd);
    case (m)
      2'b01:   return rd ? "R5" : "R2/R3";
      2'b10:   return rd ? "R6" : "R4";
      2'b11:   return "R8";
      default: return rd ? "R7" : "R1";
    endcase
  endfunction

  task automatic write_word(logic [DW:0] d, logic [1:0] m, logic odd, string extra);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; cfg_mode = m; cfg_odd = odd;
    st_q.push_back(exp_store(d, m, odd));
    st_tag.push_back({mode_tag(m, 0), extra});
    wmode[wpush] = m;
    wpush++;
  endtask

  task automatic write_idle();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_word(int idx);
    logic [DW:0] w;
    logic [1:0] m;
    w = mem[idx];
    m = wmode[idx];
    @(negedge clk);
    rd_en = 1'b1; rd_word = w; cfg_mode = m;
    case (m)
      2'b01:   rd_q.push_back({1'b1, w[DW], 1'b0, w[DW-1:0]});
      2'b10:   rd_q.push_back({w[DW], 1'b0, 1'b0, w[DW-1:0]});
      default: rd_q.push_back({1'b1, 1'b0, w});
    endcase
    rd_tag.push_back({mode_tag(m, 1), "/R10"});
  endtask

  // write-side monitor
  always @(negedge clk) begin
    if (rst_n && st_valid) begin
      if (st_q.size() == 0) check("R9 unexpected st_valid", 1, 0);
      else begin
        logic [DW:0] e;
        string t;
        e = st_q.pop_front();
        t = st_tag.pop_front();
        check(t, st_word, e);
        mem[wstore] = st_word;
        wstore++;
      end
    end
  end

  // read-side monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (rd_q.size() == 0) check("R10 unexpected rd_valid", 1, 0);
      else begin
        logic [DW+2:0] e;
        string t;
        e = rd_q.pop_front();
        t = rd_tag.pop_front();
        check(t, {rd_good, rd_par, rd_data}, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    wr_data = 9'h1ff; wr_en = 1'b1; rd_en = 1'b1; rd_word = 9'h1ff;
    repeat (3) @(negedge clk);
    // R11: reset state holds even with strobes active
    check("R11 st_valid", st_valid, 0);
    check("R11 st_word", st_word, 0);
    check("R11 rd_valid", rd_valid, 0);
    check("R11 rd_data", rd_data, 0);
    check("R11 rd_par", rd_par, 0);
    check("R11 rd_good", rd_good, 1);
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // generate mode, both polarities, every byte, bit 8 varied (R2 ignore)
    for (int odd = 0; odd < 2; odd++)
      for (int b = 0; b < 256; b++)
        write_word({b[0] ^ b[3] ^ odd[0], b[7:0]}, 2'b01, odd[0], "");
    // same byte with opposite bit 8 values back to back (R2)
    write_word(9'h0a5, 2'b01, 1'b1, " bit8-ignored");
    write_word(9'h1a5, 2'b01, 1'b1, " bit8-ignored");
    // check mode, every 9-bit word, both polarities
    for (int odd = 0; odd < 2; odd++)
      for (int w = 0; w < 512; w++)
        write_word(w[8:0], 2'b10, odd[0], "");
    // pass-through sweep
    for (int w = 0; w < 512; w += 7)
      write_word(w[8:0], 2'b00, 1'b1, "");
    // mode changes every cycle (R9), including mode 11 (R8)
    for (int i = 0; i < 64; i++)
      write_word(9'(i * 37 + 5), 2'(i), 1'(i >> 2), " R9 mode-switch");
    write_idle();
    repeat (3) @(negedge clk);
    check("R9 write queue drained", st_q.size(), 0);

    for (int i = 0; i < wstore; i++) read_word(i);
    @(negedge clk);
    rd_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 read queue drained", rd_q.size(), 0);
    check("R10 read count", wstore, wpush);
    finish_run();
  end
endmodule